// File: doc/BRIEF.md
# Memory Pattern Write-Readback Tester

This block checks one region of memory by writing a fixed sequence of 64 data words to consecutive word addresses and then reading every word back several times in a row. A calibration sequencer starts a run with a one-cycle `start_i` pulse and samples the verdict once `done_o` is high. The sequencer can use the tester to judge one delay setting after another.

The memory side is a single-request port. Requests use valid/ready. A request stays on the port, with unchanged fields, until the cycle in which ready is seen. Only one read can be outstanding, and no request is issued until the previous read's response has arrived. Responses arrive on `mem_rsp_valid_i` and have no back-pressure. The block takes a response in any cycle, but uses it only while it waits for the answer to an accepted read. The first read that does not match ends the run. The failing word index and the 0-based read number within that word are then reported.

Addresses are word addresses: word i goes to `base_addr_i + i`, modulo 2^ADDR_W. The base address is captured when the run starts.

Top module: `mem_pattern_checker`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `mem_req_valid_o` are 0.
- R2: A `start_i` pulse while idle or finished begins a new run. A `start_i` pulse during a run has no effect on the request sequence or the verdict.
- R3: A run first issues exactly 64 write requests, for words 0 to 63 in ascending order, each to address base+i. No read request is issued before the last write is accepted.
- R4: Word i is built per 16-bit lane. The group is i[5:4]: 0 gives seed 16'h0000, 1 gives 16'hAAAA, 2 gives 16'hA5A5, 3 gives 16'hAA55. When i[3] XOR i[1] is 1, the lane is the complement of the seed; otherwise it is the seed. This gives the in-group order X X Y Y X X Y Y Y Y X X Y Y X X.
- R5: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid on the next cycle and its address, write-enable and data stay unchanged.
- R6: After a read is accepted, no new request is presented until a response has been received.
- R7: In the read phase, each word is read 10 times in a row (addresses base+0 ten times, then base+1, and so on), with `mem_req_we_o` low.
- R8: The first response that differs from the expected word ends the run. `done_o` goes high with `pass_o` low, `fail_idx_o` holds the word index and `fail_rd_o` holds the 0-based read number, and no further request is issued.
- R9: `pass_o` goes high only after all 640 reads have matched. On a pass, `fail_idx_o` and `fail_rd_o` are 0.
- R10: `done_o`, `pass_o` and the fail fields hold until the next `start_i`. The cycle after a start is accepted, `done_o` is low.
- R11: A response that arrives while no read is waiting for its answer, including one in the same cycle as a read acceptance, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run (one-cycle pulse) |
| base_addr_i | input | ADDR_W | Word address of pattern word 0 |
| done_o | output | 1 | Run finished, verdict valid |
| pass_o | output | 1 | All reads matched |
| fail_idx_o | output | IDX_W | Word index of the first mismatch |
| fail_rd_o | output | RD_W | 0-based read number of the first mismatch |
| mem_req_valid_o | output | 1 | Request present |
| mem_req_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Word address |
| mem_req_wdata_o | output | DATA_W | Write data |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | DATA_W | Read data |

## Verification
Two functions can land in the same cycle.

The first pair is a start request and the sequencer's own progress during a run. The bench pulses `start_i` in the middle of a run with back-pressure active. Every later handshake is still compared against the uninterrupted expected sequence, and the final verdict is still checked.

The second pair is a read acceptance and an unsolicited response. The bench drives stray responses with wrong data while no read is outstanding, some of them in the exact cycle a read is accepted. A run that still passes shows that these responses were not taken as read data.

// File: rtl/mpc_pkg.sv
`timescale 1ns/1ps
package mpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ISSUE,
    ST_WR_ACC,
    ST_RD_ISSUE,
    ST_RD_ACC,
    ST_RD_RSP,
    ST_DONE
  } mpc_state_e;

  localparam int unsigned LANE_W = 16;

  function automatic logic [LANE_W-1:0] group_seed(input logic [1:0] grp);
    logic [LANE_W-1:0] s;
    case (grp)
      2'd0:    s = 16'h0000;
      2'd1:    s = 16'hAAAA;
      2'd2:    s = 16'hA5A5;
      default: s = 16'hAA55;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mpc_pattern_gen.sv
`timescale 1ns/1ps
module mpc_pattern_gen #(
  parameter int DATA_W = 32
) (
  input  logic [5:0]        sel_i,
  output logic [DATA_W-1:0] word_o
);
  import mpc_pkg::*;
  localparam int LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] seed;
  logic              complement;
  logic [LANE_W-1:0] lane_val;
  logic              unused_sel_bits;

  // Group from the upper bits; mirrored X/Y order from bits 3 and 1.
  assign seed            = group_seed(sel_i[5:4]);
  assign complement      = sel_i[3] ^ sel_i[1];
  assign lane_val        = complement ? ~seed : seed;
  assign unused_sel_bits = sel_i[2] ^ sel_i[0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l*LANE_W +: LANE_W] = lane_val;
  end
endmodule

// File: rtl/mpc_req_port.sv
`timescale 1ns/1ps
module mpc_req_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              accept_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (issue_i) begin
      valid_q <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign accept_o = valid_q && ready_i;
  assign valid_o  = valid_q;
  assign we_o     = we_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(we_o) && $stable(data_o)));
endmodule

// File: rtl/mpc_seq.sv
`timescale 1ns/1ps
module mpc_seq #(
  parameter int NUM_WORDS = 64,
  parameter int READS     = 10,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int RD_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              issue_o,
  output logic              iss_we_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic [DATA_W-1:0] iss_data_o,
  input  logic              accept_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic [5:0]        pat_sel_o,
  input  logic [DATA_W-1:0] pat_word_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic [RD_W-1:0]   fail_rd_o
);
  import mpc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [RD_W-1:0]  LAST_RD  = RD_W'(READS - 1);

  mpc_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RD_W-1:0]   rcnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              pass_q;
  logic [IDX_W-1:0]  fidx_q;
  logic [RD_W-1:0]   frd_q;
  logic              idle_like;
  logic              mismatch;
  logic              rd_seen_q;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign mismatch  = (rsp_data_i != pat_word_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rcnt_q  <= '0;
      base_q  <= '0;
      pass_q  <= 1'b0;
      fidx_q  <= '0;
      frd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_WR_ISSUE;
            idx_q   <= '0;
            rcnt_q  <= '0;
            base_q  <= base_i;
            pass_q  <= 1'b0;
            fidx_q  <= '0;
            frd_q   <= '0;
          end
        end
        ST_WR_ISSUE: state_q <= ST_WR_ACC;
        ST_WR_ACC: begin
          if (accept_i) begin
            if (idx_q == LAST_IDX) begin
              idx_q   <= '0;
              rcnt_q  <= '0;
              state_q <= ST_RD_ISSUE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WR_ISSUE;
            end
          end
        end
        ST_RD_ISSUE: state_q <= ST_RD_ACC;
        ST_RD_ACC: begin
          if (accept_i) state_q <= ST_RD_RSP;
        end
        ST_RD_RSP: begin
          if (rsp_valid_i) begin
            if (mismatch) begin
              state_q <= ST_DONE;
              pass_q  <= 1'b0;
              fidx_q  <= idx_q;
              frd_q   <= rcnt_q;
            end else if (rcnt_q == LAST_RD) begin
              if (idx_q == LAST_IDX) begin
                state_q <= ST_DONE;
                pass_q  <= 1'b1;
              end else begin
                idx_q   <= idx_q + 1'b1;
                rcnt_q  <= '0;
                state_q <= ST_RD_ISSUE;
              end
            end else begin
              rcnt_q  <= rcnt_q + 1'b1;
              state_q <= ST_RD_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_o    = (state_q == ST_WR_ISSUE) || (state_q == ST_RD_ISSUE);
  assign iss_we_o   = (state_q == ST_WR_ISSUE);
  assign iss_addr_o = base_q + ADDR_W'(idx_q);
  assign iss_data_o = pat_word_i;
  assign pat_sel_o  = idx_q[5:0];
  assign done_o     = (state_q == ST_DONE);
  assign pass_o     = pass_q;
  assign fail_idx_o = fidx_q;
  assign fail_rd_o  = frd_q;

  // Tracks whether a read was issued since the last start.
  always_ff @(posedge clk) begin
    if (!rst_n)                        rd_seen_q <= 1'b0;
    else if (idle_like && start_i)     rd_seen_q <= 1'b0;
    else if (issue_o && !iss_we_o)     rd_seen_q <= 1'b1;
  end

  a_r3_writes_before_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && iss_we_o) |-> !rd_seen_q);
  a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_like && start_i) |=> $stable(base_q));
  a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_idx_o) && $stable(fail_rd_o)));
endmodule

// File: rtl/mem_pattern_checker.sv
`timescale 1ns/1ps
module mem_pattern_checker #(
  parameter int NUM_WORDS = 64,
  parameter int READS     = 10,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_WORDS > 64) ? $clog2(NUM_WORDS) : 6,
  localparam int RD_W     = (READS > 1) ? $clog2(READS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic [RD_W-1:0]   fail_rd_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  logic              issue;
  logic              iss_we;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_data;
  logic              accept;
  logic [5:0]        pat_sel;
  logic [DATA_W-1:0] pat_word;

  mpc_pattern_gen #(.DATA_W(DATA_W)) u_pat (
    .sel_i  (pat_sel),
    .word_o (pat_word)
  );

  mpc_seq #(
    .NUM_WORDS(NUM_WORDS), .READS(READS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .RD_W(RD_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_i      (base_addr_i),
    .issue_o     (issue),
    .iss_we_o    (iss_we),
    .iss_addr_o  (iss_addr),
    .iss_data_o  (iss_data),
    .accept_i    (accept),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_data_i  (mem_rsp_data_i),
    .pat_sel_o   (pat_sel),
    .pat_word_i  (pat_word),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_idx_o  (fail_idx_o),
    .fail_rd_o   (fail_rd_o)
  );

  mpc_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue),
    .we_i     (iss_we),
    .addr_i   (iss_addr),
    .data_i   (iss_data),
    .accept_o (accept),
    .valid_o  (mem_req_valid_o),
    .ready_i  (mem_req_ready_i),
    .we_o     (mem_req_we_o),
    .addr_o   (mem_req_addr_o),
    .data_o   (mem_req_wdata_o)
  );

  // Independent tracker of an accepted read still awaiting its data.
  logic rd_pending_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                 rd_pending_q <= 1'b0;
    else if (accept && !mem_req_we_o)           rd_pending_q <= 1'b1;
    else if (mem_rsp_valid_i)                   rd_pending_q <= 1'b0;
  end

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending_q |-> !mem_req_valid_o);
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_valid_o);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!done_o && !pass_o && !mem_req_valid_o));
endmodule

// File: tb/mem_pattern_checker_bench.sv
`timescale 1ns/1ps
module mem_pattern_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic        done_o, pass_o;
  logic [5:0]  fail_idx_o;
  logic [3:0]  fail_rd_o;
  logic        mem_req_valid_o, mem_req_we_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o, mem_req_wdata_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  always #2.5 clk = ~clk;

  mem_pattern_checker u_mem_pattern_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .done_o(done_o), .pass_o(pass_o), .fail_idx_o(fail_idx_o), .fail_rd_o(fail_rd_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // run configuration and model state
  int          hs_n = 0;
  int          exp_total = 0;
  bit          corrupt_en = 0;
  int          c_idx = 0, c_rd = 0;
  int          rmode = 0, lmode = 0;
  bit          stray_en = 0;
  bit          active = 0;
  logic [31:0] run_base = '0;
  logic [31:0] mem [logic [31:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected pattern from R4: group seeds, Y positions 2,3,6,7,8,9,12,13.
  function automatic logic [31:0] exp_word(input int i);
    logic [15:0] seed;
    logic [15:0] ymask;
    ymask = 16'h33CC;
    case ((i / 16) % 4)
      0: seed = 16'h0000;
      1: seed = 16'hAAAA;
      2: seed = 16'hA5A5;
      default: seed = 16'hAA55;
    endcase
    if (ymask[i % 16]) seed = ~seed;
    return {seed, seed};
  endfunction

  // Memory model and per-clock comparison of every handshake.
  initial begin
    int          cyc = 0;
    bit          pend = 0;
    int          delay = 0;
    logic [31:0] pend_data = '0;
    bit          prev_stall = 0;
    logic [31:0] p_addr = '0, p_data = '0;
    logic        p_we = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        delay--;
        if (delay == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = pend_data;
          pend = 0;
        end
      end else if (stray_en && (cyc % 7 == 0)) begin
        mem_rsp_valid_i = 1'b1;        // R11 unsolicited response
        mem_rsp_data_i  = 32'h1234_5678;
      end
      if (prev_stall && active) begin
        chk(mem_req_valid_o && mem_req_addr_o == p_addr && mem_req_we_o == p_we &&
            mem_req_wdata_o == p_data, "R5", "stalled request changed",
            {31'd0, mem_req_valid_o, mem_req_addr_o}, {32'd1, p_addr});
      end
      mem_req_ready_i = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      prev_stall = mem_req_valid_o && !mem_req_ready_i;
      p_addr = mem_req_addr_o; p_data = mem_req_wdata_o; p_we = mem_req_we_o;
      if (mem_req_valid_o && mem_req_ready_i && active) begin
        int n;
        n = hs_n;
        chk(!pend, "R6", "request while read outstanding", 64'(n), 64'd0);
        if (n >= exp_total) begin
          chk(1'b0, "R8", "extra request after end", 64'(n), 64'(exp_total));
        end else if (n < 64) begin
          chk(mem_req_we_o == 1'b1 && mem_req_addr_o == run_base + 32'(n),
              "R3", "write order/address", {31'd0, mem_req_we_o, mem_req_addr_o},
              {32'd1, run_base + 32'(n)});
          chk(mem_req_wdata_o == exp_word(n), "R4", "write data",
              64'(mem_req_wdata_o), 64'(exp_word(n)));
          mem[mem_req_addr_o] = mem_req_wdata_o;
        end else begin
          int w, o;
          w = (n - 64) / 10;
          o = (n - 64) % 10;
          chk(mem_req_we_o == 1'b0 && mem_req_addr_o == run_base + 32'(w),
              "R7", "read order/address", {31'd0, mem_req_we_o, mem_req_addr_o},
              {32'd0, run_base + 32'(w)});
          pend_data = mem.exists(mem_req_addr_o) ? mem[mem_req_addr_o] : 32'hDEAD_BEEF;
          if (corrupt_en && w == c_idx && o == c_rd) pend_data = pend_data ^ 32'h0000_0100;
          pend  = 1;
          delay = (lmode == 0) ? 1 : 1 + (n % 3);
        end
        hs_n = n + 1;
      end
    end
  end

  task automatic run_test(input logic [31:0] base, input bit cor, input int ci, input int cr,
                          input int rm, input int lm, input bit stray, input bit busy_start);
    int  t;
    bit  ok_pass;
    run_base = base; corrupt_en = cor; c_idx = ci; c_rd = cr;
    rmode = rm; lmode = lm; stray_en = stray;
    hs_n = 0;
    exp_total = cor ? 64 + ci * 10 + cr + 1 : 64 + 640;
    active = 1;
    @(negedge clk);
    base_addr_i = base;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    base_addr_i = 32'h5555_0000;   // later changes must not matter
    chk(done_o == 1'b0, "R10", "done cleared after start", 64'(done_o), 64'd0);
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
      if (busy_start && t == 100) start_i = 1'b1;   // R2 start during run
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R8", "run did not finish", 64'(done_o), 64'd1);
    ok_pass = !cor;
    chk(pass_o == ok_pass, cor ? "R8" : "R9", "verdict", 64'(pass_o), 64'(ok_pass));
    chk(fail_idx_o == 6'(cor ? ci : 0), cor ? "R8" : "R9", "fail index",
        64'(fail_idx_o), 64'(cor ? ci : 0));
    chk(fail_rd_o == 4'(cor ? cr : 0), cor ? "R8" : "R9", "fail read number",
        64'(fail_rd_o), 64'(cor ? cr : 0));
    chk(hs_n == exp_total, busy_start ? "R2" : "R8", "request count",
        64'(hs_n), 64'(exp_total));
    repeat (8) @(negedge clk);
    chk(done_o == 1'b1 && pass_o == ok_pass, "R10", "verdict held",
        {62'd0, done_o, pass_o}, {62'd0, 1'b1, ok_pass});
    chk(hs_n == exp_total && !mem_req_valid_o, "R8", "quiet after done",
        64'(hs_n), 64'(exp_total));
    active = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(done_o == 0 && pass_o == 0 && mem_req_valid_o == 0, "R1", "reset state",
        {61'd0, done_o, pass_o, mem_req_valid_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 0 && pass_o == 0 && mem_req_valid_o == 0, "R1", "idle after reset",
        {61'd0, done_o, pass_o, mem_req_valid_o}, 64'd0);
    run_test(32'h0000_1000, 0, 0, 0, 0, 0, 0, 0);   // clean pass
    run_test(32'hFFFF_FFE0, 0, 0, 0, 1, 1, 1, 1);   // stalls, stray rsp (R11), busy start, wrap
    run_test(32'h0000_4000, 1, 37, 4, 0, 1, 0, 0);  // mid fail
    run_test(32'h0000_0000, 1, 0, 0, 1, 0, 1, 0);   // first read fails
    run_test(32'h0001_0000, 1, 63, 9, 1, 1, 0, 0);  // last read fails
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule